// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits between a simple host request port and a 16-bit single-data-rate SDRAM with four banks, 8192 rows and 512 columns. Each accepted host request, a read or a write of one 16-bit word, becomes a short command train on the memory pins. The train opens the row, issues the column access with self-timed precharge requested, and waits out the recovery time before the next command. Read data comes back to the host a fixed number of cycles after the column command, set by the CAS latency parameter (2 or 3).

After reset the block runs a fixed bring-up sequence before it accepts any request. It waits a parameterised number of cycles, closes all banks, issues two refresh commands and then programs the mode register. From then on a refresh timer spreads `REF_COUNT` refreshes evenly over a window of `REF_WINDOW_CYC` cycles. A refresh that is due goes ahead of any waiting host request once the access in flight has finished. Every pin is driven from a register, and the block drives NOP whenever it is waiting on a timing gap.

Top module: `sdram_seq`

## Requirements
- R1: During reset and for at least `INIT_CYCLES` cycles after it, the pins carry only NOP (chip select low, RAS/CAS/WE high) with both DQM bits high. `req_ready` stays low until the mode register has been programmed.
- R2: Bring-up issues, in order: PRECHARGE with A10 high; REFRESH; REFRESH; LOAD MODE. The gaps are at least `T_RP`, `T_RFC` and `T_RFC` cycles. The mode word has burst length field A2..A0 = 000, burst type A3 = 0, CAS latency in A6..A4, and every other bit and BA at zero.
- R3: Commands use {cs_n,ras_n,cas_n,we_n} = NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, LOAD MODE 0000.
- R4: The host byte address is split as follows: bit 0 is ignored, bits 9..1 give the column, bits 22..10 the row and bits 24..23 the bank. ACTIVE carries the bank on BA and the row on A. READ/WRITE carry the same bank, the column on A8..A0 and A10 high, with all other address bits low.
- R5: The READ or WRITE follows its ACTIVE by exactly `T_RCD` cycles.
- R6: Suppose a READ is on the pins in cycle c. Then `rd_valid` is high for one cycle in cycle c+`CAS_LAT`+1, and `rd_data` holds the word on `sd_dq_in` at the clock edge that ends cycle c+`CAS_LAT`. Results return in request order.
- R7: `sd_dq_oe` is high only in a WRITE cycle, and there `sd_dq_out` holds the host word. DQM is 00 from the mode-register command onward.
- R8: No ACTIVE reaches a bank earlier than `T_WR`+`T_RP` cycles after a WRITE, or `CAS_LAT`+`T_RP` cycles after a READ.
- R9: A refresh is due every `REF_WINDOW_CYC`/`REF_COUNT` cycles. No due refresh is lost, and each is issued within a bounded delay while all banks are closed.
- R10: A due refresh is issued before a pending host request. No command other than NOP follows a REFRESH within `T_RFC` cycles.
- R11: A request is taken only in a cycle with `req_valid` and `req_ready` both high. Each one produces exactly one ACTIVE plus one READ or WRITE, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is registered on its rising edge |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 25 | Host byte address |
| req_wdata | input | 16 | Write word |
| req_ready | output | 1 | Request taken this cycle when valid |
| rd_valid | output | 1 | Read word available |
| rd_data | output | 16 | Read word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 13 | Row / column / op-code address |
| sd_dqm | output | 2 | Byte masks |
| sd_dq_out | output | 16 | Data driven toward the memory |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | 16 | Data returned by the memory |

## Verification
The embedded assertions watch several rules on every cycle: the exact row-to-column gap, the quiet period after each refresh, the read-latency relationship between a READ on the pins and `rd_valid`, refresh acknowledgement only when due, and the absence of host acceptance before bring-up ends. Other properties need the bench's behavioural memory, which watches the pins over whole scenarios. These are the order and op-code of the bring-up train, the bank-close gaps after reads and writes, the address split at the extreme bank, row and column values, and the data actually returned. The same holds for refresh keeping its period while a continuous stream of host requests competes with it.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_INIT_REF1,
        ST_INIT_REF2,
        ST_INIT_LMR,
        ST_IDLE,
        ST_ACCESS
    } seq_state_e;

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int INTERVAL = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ack,
    output logic ref_due
);
    localparam int CNT_W = $clog2(INTERVAL + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             due;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic wrap;

    always_comb begin
        tmr_d = tmr_q;
        wrap  = (tmr_q.cnt == CNT_W'(INTERVAL - 1));
        tmr_d.cnt = wrap ? '0 : tmr_q.cnt + 1'b1;
        if (wrap)         tmr_d.due = 1'b1;
        else if (ref_ack) tmr_d.due = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign ref_due = tmr_q.due;

    // R9: a pending refresh is never dropped before it is acknowledged
    assert_due_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_due && !ref_ack) |=> ref_due);

endmodule

// File: rtl/sdram_read_capture.sv
module sdram_read_capture #(
    parameter int CAS_LAT = 3,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [CAS_LAT:0]  pipe;
        logic              valid;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.pipe  = {cap_q.pipe[CAS_LAT-1:0], rd_issue};
        cap_d.valid = cap_q.pipe[CAS_LAT];
        if (cap_q.pipe[CAS_LAT]) cap_d.data = dq_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign rd_valid = cap_q.valid;
    assign rd_data  = cap_q.data;

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
    import sdram_seq_pkg::*;
#(
    parameter int BANK_W         = 2,
    parameter int ROW_W          = 13,
    parameter int COL_W          = 9,
    parameter int DATA_W         = 16,
    parameter int CAS_LAT        = 3,
    parameter int T_RCD          = 2,
    parameter int T_RP           = 2,
    parameter int T_WR           = 2,
    parameter int T_RFC          = 7,
    parameter int T_MRD          = 2,
    parameter int INIT_CYCLES    = 20000,
    parameter int REF_WINDOW_CYC = 6400000,
    parameter int REF_COUNT      = 8192
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [BANK_W+ROW_W+COL_W:0] req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      req_ready,
    output logic                      rd_valid,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      sd_cs_n,
    output logic                      sd_ras_n,
    output logic                      sd_cas_n,
    output logic                      sd_we_n,
    output logic [BANK_W-1:0]         sd_ba,
    output logic [ROW_W-1:0]          sd_addr,
    output logic [DATA_W/8-1:0]       sd_dqm,
    output logic [DATA_W-1:0]         sd_dq_out,
    output logic                      sd_dq_oe,
    input  logic [DATA_W-1:0]         sd_dq_in
);
    localparam int ADDR_W    = BANK_W + ROW_W + COL_W + 1;
    localparam int DQM_W     = DATA_W / 8;
    localparam int AP_BIT    = 10;
    localparam int RD_GAP    = CAS_LAT + T_RP;
    localparam int WR_GAP    = T_WR + T_RP;
    localparam int REF_IVL   = REF_WINDOW_CYC / REF_COUNT;
    localparam int TIMER_MAX = INIT_CYCLES + RD_GAP + WR_GAP + T_RFC + T_MRD + T_RCD;
    localparam int TIMER_W   = $clog2(TIMER_MAX + 1);
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

    typedef struct packed {
        seq_state_e          state;
        logic [TIMER_W-1:0]  timer;
        sd_cmd_e             cmd;
        logic [BANK_W-1:0]   ba;
        logic [ROW_W-1:0]    addr;
        logic [DQM_W-1:0]    dqm;
        logic [DATA_W-1:0]   dq_out;
        logic                dq_oe;
        logic                pend_write;
        logic [COL_W-1:0]    pend_col;
        logic                init_done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic ref_due, ref_ack, tick, rd_issue;
    logic unused_byte_bit;

    assign unused_byte_bit = req_addr[0];
    assign tick      = (seq_q.timer == '0);
    assign req_ready = (seq_q.state == ST_IDLE) && tick && !ref_due;

    always_comb begin
        seq_d       = seq_q;
        seq_d.cmd   = CMD_NOP;
        seq_d.dq_oe = 1'b0;
        ref_ack     = 1'b0;
        if (!tick) seq_d.timer = seq_q.timer - 1'b1;
        unique case (seq_q.state)
            ST_POWERUP: if (tick) begin
                seq_d.cmd          = CMD_PRE;
                seq_d.addr         = '0;
                seq_d.addr[AP_BIT] = 1'b1;
                seq_d.timer        = TIMER_W'(T_RP - 1);
                seq_d.state        = ST_INIT_REF1;
            end
            ST_INIT_REF1: if (tick) begin
                seq_d.cmd   = CMD_REF;
                seq_d.timer = TIMER_W'(T_RFC - 1);
                seq_d.state = ST_INIT_REF2;
            end
            ST_INIT_REF2: if (tick) begin
                seq_d.cmd   = CMD_REF;
                seq_d.timer = TIMER_W'(T_RFC - 1);
                seq_d.state = ST_INIT_LMR;
            end
            ST_INIT_LMR: if (tick) begin
                seq_d.cmd       = CMD_LMR;
                seq_d.ba        = '0;
                seq_d.addr      = MODE_WORD;
                seq_d.dqm       = '0;
                seq_d.init_done = 1'b1;
                seq_d.timer     = TIMER_W'(T_MRD - 1);
                seq_d.state     = ST_IDLE;
            end
            ST_IDLE: if (tick) begin
                if (ref_due) begin
                    seq_d.cmd   = CMD_REF;
                    ref_ack     = 1'b1;
                    seq_d.timer = TIMER_W'(T_RFC - 1);
                end else if (req_valid) begin
                    seq_d.cmd        = CMD_ACT;
                    seq_d.ba         = req_addr[ADDR_W-1 -: BANK_W];
                    seq_d.addr       = req_addr[COL_W+ROW_W : COL_W+1];
                    seq_d.pend_col   = req_addr[COL_W:1];
                    seq_d.pend_write = req_write;
                    seq_d.dq_out     = req_wdata;
                    seq_d.timer      = TIMER_W'(T_RCD - 1);
                    seq_d.state      = ST_ACCESS;
                end
            end
            ST_ACCESS: if (tick) begin
                seq_d.cmd                 = seq_q.pend_write ? CMD_WR : CMD_RD;
                seq_d.addr                = '0;
                seq_d.addr[COL_W-1:0]     = seq_q.pend_col;
                seq_d.addr[AP_BIT]        = 1'b1;
                seq_d.dq_oe               = seq_q.pend_write;
                seq_d.timer               = seq_q.pend_write ? TIMER_W'(WR_GAP - 1)
                                                             : TIMER_W'(RD_GAP - 1);
                seq_d.state               = ST_IDLE;
            end
            default: seq_d.state = ST_POWERUP;
        endcase
    end

    assign rd_issue = (seq_d.cmd == CMD_RD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_POWERUP, timer: TIMER_W'(INIT_CYCLES - 1), cmd: CMD_NOP,
                       ba: '0, addr: '0, dqm: '1, dq_out: '0, dq_oe: 1'b0,
                       pend_write: 1'b0, pend_col: '0, init_done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = seq_q.cmd;
    assign sd_ba     = seq_q.ba;
    assign sd_addr   = seq_q.addr;
    assign sd_dqm    = seq_q.dqm;
    assign sd_dq_out = seq_q.dq_out;
    assign sd_dq_oe  = seq_q.dq_oe;

    sdram_refresh_timer #(.INTERVAL(REF_IVL)) u_ref (
        .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_due(ref_due));

    sdram_read_capture #(.CAS_LAT(CAS_LAT), .DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .dq_in(sd_dq_in),
        .rd_valid(rd_valid), .rd_data(rd_data));

    // ---------------- checks on the pin stream ----------------
    logic [3:0] pin_cmd;
    logic       pin_rd, pin_rw;
    logic [7:0] act_age_q, ref_age_q;

    assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign pin_rd  = (pin_cmd == CMD_RD);
    assign pin_rw  = pin_rd || (pin_cmd == CMD_WR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_age_q <= '1;
            ref_age_q <= '1;
        end else begin
            act_age_q <= (pin_cmd == CMD_ACT) ? 8'd1 : (act_age_q == '1 ? act_age_q : act_age_q + 1'b1);
            ref_age_q <= (pin_cmd == CMD_REF) ? 8'd1 : (ref_age_q == '1 ? ref_age_q : ref_age_q + 1'b1);
        end
    end

    assert_trcd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rw |-> (act_age_q == 8'(T_RCD)));

    assert_refresh_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_age_q < 8'(T_RFC)) |-> (pin_cmd == CMD_NOP));

    assert_ack_only_when_due_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> ref_due);

    assert_read_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(pin_rd, CAS_LAT + 1));

    assert_no_accept_early_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> seq_q.init_done);

endmodule

// File: tb/tb_sdram_seq.sv
module tb_sdram_seq;
    localparam int CLK_PERIOD  = 10;
    localparam int CAS_LAT     = 3;
    localparam int T_RCD       = 2;
    localparam int T_RP        = 2;
    localparam int T_WR        = 2;
    localparam int T_RFC       = 7;
    localparam int INIT_CYCLES = 20;
    localparam int INTERVAL    = 80;
    localparam int SLACK       = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [24:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [15:0] rd_data;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba, sd_dqm;
    logic [12:0] sd_addr;
    logic [15:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [15:0] sd_dq_in = 16'hdead;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_seq #(.CAS_LAT(CAS_LAT), .T_RCD(T_RCD), .T_RP(T_RP), .T_WR(T_WR),
                .T_RFC(T_RFC), .INIT_CYCLES(INIT_CYCLES),
                .REF_WINDOW_CYC(8192 * INTERVAL), .REF_COUNT(8192)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

    int total = 0, bad = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0h exp %0h", req, what, act, exp);
        end
    endtask

    typedef struct { int bank; int row; int col; bit wr; } acc_t;
    acc_t        acc_q[$];
    logic [15:0] exp_q[$];
    logic [15:0] ref_mem[int];

    // behavioural memory and result monitor
    logic [15:0] mem[int];
    int rd_due[$];
    logic [15:0] rd_val[$];
    int rdv_q[$];
    int cyc = 0, rel_cyc = -1, init_step = 0, last_cmd = 0, last_ref = -1;
    int post_ref = -1, ref_cnt = 0, init_done_cyc = 0;
    bit bank_open[4];
    int act_cyc[4], bank_free[4];

    always @(negedge clk) begin
        logic [3:0] c;
        int b, key;
        cyc++;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (rst_n) begin
            if (rel_cyc < 0) rel_cyc = cyc;
            if (sd_dq_oe && c != 4'b0100) check(0, "R7", "dq_oe outside write", c, 4'b0100);
            if (c != 4'b0111) begin
                if (last_ref >= 0 && cyc - last_ref < T_RFC)
                    check(0, "R10", "command inside refresh gap", cyc - last_ref, T_RFC);
            end
            if (c != 4'b0111 && init_step < 4) begin
                case (init_step)
                    0: begin
                        check(c == 4'b0010 && sd_addr[10], "R2", "first init cmd precharge-all", c, 4'b0010);
                        check(cyc - rel_cyc >= INIT_CYCLES, "R1", "power-up wait", cyc - rel_cyc, INIT_CYCLES);
                        check(sd_dqm == 2'b11, "R1", "dqm during init", sd_dqm, 2'b11);
                    end
                    1: begin
                        check(c == 4'b0001, "R2", "second init cmd refresh", c, 4'b0001);
                        check(cyc - last_cmd >= T_RP, "R2", "tRP after precharge", cyc - last_cmd, T_RP);
                    end
                    2: begin
                        check(c == 4'b0001, "R2", "third init cmd refresh", c, 4'b0001);
                        check(cyc - last_cmd >= T_RFC, "R2", "tRFC gap", cyc - last_cmd, T_RFC);
                    end
                    default: begin
                        check(c == 4'b0000, "R2", "fourth init cmd load mode", c, 4'b0000);
                        check(sd_addr == 13'(CAS_LAT << 4) && sd_ba == 0, "R2", "mode word",
                              sd_addr, CAS_LAT << 4);
                        check(cyc - last_cmd >= T_RFC, "R2", "tRFC before mode", cyc - last_cmd, T_RFC);
                        init_done_cyc = cyc;
                    end
                endcase
                init_step++;
            end else if (c != 4'b0111) begin
                b = sd_ba;
                case (c)
                    4'b0011: begin
                        check(!bank_open[b] && cyc >= bank_free[b], "R8", "activate to busy bank",
                              cyc, bank_free[b]);
                        if (acc_q.size() == 0) check(0, "R11", "activate without request", 1, 0);
                        else check(acc_q[0].bank == b && acc_q[0].row == sd_addr, "R4", "bank/row",
                                   {b, sd_addr}, {acc_q[0].bank, acc_q[0].row});
                        bank_open[b] = 1; act_cyc[b] = cyc;
                    end
                    4'b0101, 4'b0100: begin
                        check(bank_open[b], "R4", "column cmd bank open", b, b);
                        check(cyc - act_cyc[b] == T_RCD, "R5", "tRCD", cyc - act_cyc[b], T_RCD);
                        check(sd_addr[10] && sd_addr[12:11] == 0 && sd_addr[9] == 0, "R4",
                              "auto-precharge column word", sd_addr, 13'h400);
                        if (acc_q.size() != 0) begin
                            check(acc_q[0].col == int'(sd_addr[8:0]) && acc_q[0].wr == (c == 4'b0100),
                                  "R11", "column/direction", sd_addr[8:0], acc_q[0].col);
                            key = (acc_q[0].bank << 22) | (acc_q[0].row << 9) | acc_q[0].col;
                            void'(acc_q.pop_front());
                        end else key = 0;
                        bank_open[b] = 0;
                        if (c == 4'b0100) begin
                            check(sd_dq_oe && sd_dqm == 2'b00, "R7", "write drive", {sd_dq_oe, sd_dqm}, 3'b100);
                            mem[key] = sd_dq_out;
                            bank_free[b] = cyc + T_WR + T_RP;
                        end else begin
                            rd_due.push_back(cyc + CAS_LAT);
                            rd_val.push_back(mem.exists(key) ? mem[key] : 16'h0);
                            bank_free[b] = cyc + CAS_LAT + T_RP;
                        end
                    end
                    4'b0001: begin
                        for (int i = 0; i < 4; i++)
                            check(!bank_open[i] && cyc >= bank_free[i], "R9", "refresh with bank busy", i, 0);
                        if (post_ref >= 0)
                            check(cyc - post_ref <= INTERVAL + SLACK, "R9", "refresh period",
                                  cyc - post_ref, INTERVAL + SLACK);
                        post_ref = cyc; ref_cnt++;
                    end
                    default: check(0, "R3", "unexpected command", c, 4'b0111);
                endcase
            end
            if (c == 4'b0001) last_ref = cyc;
            if (c != 4'b0111) last_cmd = cyc;
            if (rd_due.size() != 0 && rd_due[0] == cyc) begin
                void'(rd_due.pop_front());
                sd_dq_in = rd_val.pop_front();
                rdv_q.push_back(cyc + 1);
            end else sd_dq_in = 16'hdead;
            if (rd_valid) begin
                if (rdv_q.size() == 0) check(0, "R6", "unexpected rd_valid", cyc, 0);
                else check(rdv_q.pop_front() == cyc, "R6", "read latency", cyc, cyc);
                if (exp_q.size() == 0) check(0, "R11", "read result without request", rd_data, 0);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R6", "read data", rd_data, e);
                end
            end
        end
    end

    task automatic host(bit wr, int bank, int row, int col, logic [15:0] d);
        int key;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wdata = d;
        req_addr = {bank[1:0], row[12:0], col[8:0], 1'b1};
        while (!req_ready) @(negedge clk);
        key = (bank << 22) | (row << 9) | col;
        acc_q.push_back('{bank, row, col, wr});
        if (wr) ref_mem[key] = d;
        else exp_q.push_back(ref_mem.exists(key) ? ref_mem[key] : 16'h0);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R3", "NOP in reset",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        check(sd_dqm == 2'b11 && !req_ready && !rd_valid, "R1", "reset outputs",
              {sd_dqm, req_ready, rd_valid}, 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);
        check(!req_ready, "R1", "ready low during bring-up", req_ready, 0);
        host(1, 0, 0, 0, 16'h1234);
        host(0, 0, 0, 0, 16'h0);
        host(1, 3, 8191, 511, 16'hbeef);
        host(1, 2, 4096, 256, 16'h5a5a);
        host(0, 3, 8191, 511, 16'h0);
        host(0, 2, 4096, 256, 16'h0);
        host(0, 1, 77, 3, 16'h0);
        for (int i = 0; i < 16; i++)
            host(1, i % 4, (i * 613) % 8192, (i * 37) % 512, 16'(i * 16'h1111 + 7));
        for (int i = 15; i >= 0; i--)
            host(0, i % 4, (i * 613) % 8192, (i * 37) % 512, 16'h0);
        for (int i = 0; i < 60; i++)
            host(0, i % 4, (i * 613) % 8192, (i * 37) % 512, 16'h0);
        repeat (2000) @(negedge clk);
        check(exp_q.size() == 0 && acc_q.size() == 0, "R11", "all requests completed",
              exp_q.size() + acc_q.size(), 0);
        check(ref_cnt >= (cyc - init_done_cyc) / INTERVAL - 1, "R9", "refresh count",
              ref_cnt, (cyc - init_done_cyc) / INTERVAL - 1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(0, "R11", "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule